// File: doc/BRIEF.md
# Fixed-Point First-Order Lead/Lag Filter

This block is a single first-order recursive filter section with one real zero and one real pole, used for lead compensation, lag compensation, integration and differentiation in a fixed-point control path. On each cycle where `inValid` is high it takes one input sample and returns one output sample a cycle later. The output is built from the present input, the input of the previous accepted sample and the stored previous output.

The recurrence is y(k) = p·y(k−1) + g·u(k) − ga·u(k−1). Here p is the pole, g = K·(1 − p) is the adjusted feed-forward gain, and ga = g·a is the zero-weighted gain, which the caller supplies already multiplied out. All three coefficients are run-time inputs. They use signed Q1.(BASE_W−2) format, with BASE_W−2 fraction bits, so +1 is 2^(BASE_W−2) and −1 is its negative.

Inputs, coefficients and the fed-back state are BASE_W bits wide. The three products and their sum are formed at ACC_W bits, and that wide sum is the output. The copy kept for feedback is narrowed back to BASE_W bits by rounding and saturating. ACC_W must be at least 2·BASE_W+2.

Top module: `leadlag_filter`

## Requirements
- R1: While `rst` is high on a rising edge, the block clears both delay registers and the output to zero and drives `outValid` low on the next cycle. The first sample after reset is therefore computed with u(k−1) = 0 and y(k−1) = 0.
- R2: On an edge where `inValid` is high, `yOut` becomes the exact ACC_W-bit value pCoef·yState + gCoef·uIn − gaCoef·uPrev. The value is formed from the coefficients and input present on that edge, and `outValid` is high for exactly the following cycle.
- R3: On an edge where `inValid` is low, `yOut` and both delay registers hold, whatever `uIn` and the coefficients do. `outValid` is low the following cycle.
- R4: The stored state is the ACC_W sum shifted right by BASE_W−2 bits with round-half-up, that is floor((sum + 2^(BASE_W−3)) / 2^(BASE_W−2)). An exact half rounds toward plus infinity, including for negative sums.
- R5: If the rounded state exceeds the signed BASE_W range, it saturates to 2^(BASE_W−1)−1 or −2^(BASE_W−1). A non-negative sum never stores a negative state, and a negative sum never stores a positive state.
- R6: With pCoef = +1 (2^(BASE_W−2)) and gaCoef = 0, the block integrates. A constant input makes the output ramp by gCoef·u each sample until the stored state clamps at the base-range limit.
- R7: With gaCoef = gCoef (zero at +1) and pCoef = 0, the block differentiates. A constant input gives zero output from the second sample on, and a step gives gCoef times the step size.
- R8: Extreme coefficients (−2 and just under +2) with full-scale inputs produce the exact sum at ACC_W bits, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample present this cycle |
| uIn | input | BASE_W | Input sample, signed |
| pCoef | input | BASE_W | Pole coefficient, signed Q1.(BASE_W−2) |
| gCoef | input | BASE_W | Feed-forward gain g, signed Q1.(BASE_W−2) |
| gaCoef | input | BASE_W | Product g·a, signed Q1.(BASE_W−2) |
| outValid | output | 1 | Output sample present this cycle |
| yOut | output | ACC_W | Output sample, signed, BASE_W−2 more fraction bits than uIn |

## Verification
Every result is due exactly one rising edge after the edge that accepted the sample. That edge updates `yOut`, `outValid` and both delay registers together. The bench drives inputs just after a falling edge and compares the outputs at the next falling edge, half a period after the register update. Each comparison is therefore made against the model for the sample just driven. The narrowed state has no port of its own, so its rounding and clamping are judged one sample later: a pole of +1 with zero gains copies the state into the output.

// File: rtl/leadlag_pkg.sv
package leadlag_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // synchronous clear of all datapath registers
    logic capture;  // accept one sample this edge
  } llStrobe_t;

endpackage

// File: rtl/leadlag_narrow.sv
module leadlag_narrow #(
  parameter int ACC_W  = 34,
  parameter int BASE_W = 16,
  parameter int FRAC   = BASE_W - 2
) (
  input  logic signed [ACC_W-1:0]  wideIn,
  output logic signed [BASE_W-1:0] narrowOut
);
  localparam int RW = ACC_W - FRAC + 1;
  localparam logic signed [ACC_W:0]  HALF  = (ACC_W+1)'(1) <<< (FRAC - 1);
  localparam logic signed [RW-1:0]   MAX_R = RW'((2 ** (BASE_W - 1)) - 1);
  localparam logic signed [RW-1:0]   MIN_R = ~MAX_R;

  logic signed [ACC_W:0] biased;
  logic signed [RW-1:0]  rounded;

  always_comb begin
    biased  = (ACC_W+1)'(wideIn) + HALF;
    rounded = biased[ACC_W:FRAC];
    if (rounded > MAX_R)      narrowOut = MAX_R[BASE_W-1:0];
    else if (rounded < MIN_R) narrowOut = MIN_R[BASE_W-1:0];
    else                      narrowOut = rounded[BASE_W-1:0];
  end
endmodule

// File: rtl/leadlag_ctrl.sv
module leadlag_ctrl
  import leadlag_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output llStrobe_t strobe,
  output logic      outValid
);
  always_comb begin
    strobe.clear   = rst;
    strobe.capture = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !outValid);
  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
endmodule

// File: rtl/leadlag_datapath.sv
module leadlag_datapath
  import leadlag_pkg::*;
#(
  parameter int BASE_W = 16,
  parameter int ACC_W  = 34,
  parameter int FRAC   = BASE_W - 2
) (
  input  logic                     clk,
  input  llStrobe_t                strobe,
  input  logic signed [BASE_W-1:0] uIn,
  input  logic signed [BASE_W-1:0] pCoef,
  input  logic signed [BASE_W-1:0] gCoef,
  input  logic signed [BASE_W-1:0] gaCoef,
  output logic signed [ACC_W-1:0]  yOut
);
  localparam int PROD_W = 2 * BASE_W;
  localparam int TERMS  = 3;

  logic signed [BASE_W-1:0] uPrev, yPrev, yNarrow;
  logic signed [BASE_W-1:0] coefSel [TERMS];
  logic signed [BASE_W-1:0] dataSel [TERMS];
  logic signed [ACC_W-1:0]  termExt [TERMS];
  logic signed [ACC_W-1:0]  accSum;

  // term 0: pole feedback, term 1: current input, term 2: previous input
  always_comb begin
    coefSel[0] = pCoef;  dataSel[0] = yPrev;
    coefSel[1] = gCoef;  dataSel[1] = uIn;
    coefSel[2] = gaCoef; dataSel[2] = uPrev;
  end

  for (genvar t = 0; t < TERMS; t++) begin : g_term
    logic signed [PROD_W-1:0] prod;
    assign prod       = PROD_W'(coefSel[t]) * PROD_W'(dataSel[t]);
    assign termExt[t] = ACC_W'(prod);
  end

  assign accSum = termExt[0] + termExt[1] - termExt[2];

  leadlag_narrow #(.ACC_W(ACC_W), .BASE_W(BASE_W), .FRAC(FRAC)) i_narrow (
    .wideIn   (accSum),
    .narrowOut(yNarrow)
  );

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      uPrev <= '0;
      yPrev <= '0;
      yOut  <= '0;
    end else if (strobe.capture) begin
      uPrev <= uIn;
      yPrev <= yNarrow;
      yOut  <= accSum;
    end
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk)
    strobe.clear |=> (yOut == '0 && yPrev == '0 && uPrev == '0));
  // R3
  hold_state_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.capture |=> ($stable(yOut) && $stable(yPrev) && $stable(uPrev)));
  // R2
  input_delay_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.capture |=> (uPrev == $past(uIn)));
  // R5
  pos_sign_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.capture && !accSum[ACC_W-1]) |=> !yPrev[BASE_W-1]);
  // R5
  neg_sign_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.capture && accSum[ACC_W-1]) |=> (yPrev[BASE_W-1] || yPrev == '0));
endmodule

// File: rtl/leadlag_filter.sv
module leadlag_filter
  import leadlag_pkg::*;
#(
  parameter int BASE_W = 16,
  parameter int ACC_W  = 2 * BASE_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [BASE_W-1:0] uIn,
  input  logic signed [BASE_W-1:0] pCoef,
  input  logic signed [BASE_W-1:0] gCoef,
  input  logic signed [BASE_W-1:0] gaCoef,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  yOut
);
  localparam int FRAC = BASE_W - 2;

  llStrobe_t strobe;

  leadlag_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  leadlag_datapath #(.BASE_W(BASE_W), .ACC_W(ACC_W), .FRAC(FRAC)) i_datapath (
    .clk   (clk),
    .strobe(strobe),
    .uIn   (uIn),
    .pCoef (pCoef),
    .gCoef (gCoef),
    .gaCoef(gaCoef),
    .yOut  (yOut)
  );

  // R2
  out_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(yOut));
endmodule

// File: tb/test_leadlag_filter.sv
module test_leadlag_filter;
  localparam int BASE_W = 16;
  localparam int ACC_W  = 2 * BASE_W + 2;
  localparam int FRAC   = BASE_W - 2;
  localparam longint ONE  = longint'(1) <<< FRAC;
  localparam longint SMAX = (longint'(1) <<< (BASE_W - 1)) - 1;
  localparam longint SMIN = -(longint'(1) <<< (BASE_W - 1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [BASE_W-1:0] uIn = '0, pCoef = '0, gCoef = '0, gaCoef = '0;
  logic outValid;
  logic signed [ACC_W-1:0] yOut;

  int compared = 0, mismatched = 0;
  longint mUPrev = 0, mYState = 0, mOut = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  leadlag_filter #(.BASE_W(BASE_W), .ACC_W(ACC_W)) i_leadlag_filter (
    .clk(clk), .rst(rst), .inValid(inValid), .uIn(uIn), .pCoef(pCoef),
    .gCoef(gCoef), .gaCoef(gaCoef), .outValid(outValid), .yOut(yOut)
  );

  function automatic longint narrowRef(input longint s);
    longint r = (s + (ONE / 2)) >>> FRAC;
    if (r > SMAX) return SMAX;
    if (r < SMIN) return SMIN;
    return r;
  endfunction

  task automatic compare(input bit expV, input longint expY, input string tag);
    compared++;
    if (outValid !== expV || longint'(yOut) != expY) begin
      mismatched++;
      $display("FAIL %s: outValid=%0b yOut=%0d expected outValid=%0b yOut=%0d",
               tag, outValid, longint'(yOut), expV, expY);
    end
  endtask

  task automatic setCoef(input longint p, input longint g, input longint ga);
    pCoef = BASE_W'(p); gCoef = BASE_W'(g); gaCoef = BASE_W'(ga);
  endtask

  // one cycle: drive after negedge, check at next negedge
  task automatic step(input bit v, input longint u, input string tag);
    longint s;
    inValid = v;
    uIn = BASE_W'(u);
    if (v) begin
      s = longint'(pCoef) * mYState + longint'(gCoef) * u - longint'(gaCoef) * mUPrev;
      mOut = s;
      mUPrev = u;
      mYState = narrowRef(s);
    end
    @(negedge clk);
    compare(v, mOut, tag);
  endtask

  task automatic doReset(input string tag);
    rst = 1'b1; inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mUPrev = 0; mYState = 0; mOut = 0;
    compare(1'b0, 0, tag);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stimulus
    int seed = 12345;
    @(negedge clk);
    doReset("R1 reset state");

    // R2 R4 general lead/lag: p=0.5, g=0.25, a=-0.5
    setCoef(ONE / 2, ONE / 4, -(ONE / 8));
    for (int i = 0; i < 40; i++) begin
      seed = seed * 1103515245 + 12345;
      step(1'b1, longint'($signed(seed[30:15])), "R2 general sample");
    end

    // R3 gaps with changing input and coefficients
    for (int i = 0; i < 20; i++) begin
      seed = seed * 1103515245 + 12345;
      if (i % 3 == 0) step(1'b1, longint'($signed(seed[30:15])), "R2 after gap");
      else begin
        pCoef = seed[20:5];
        step(1'b0, longint'($signed(seed[29:14])), "R3 hold while idle");
        setCoef(ONE / 2, ONE / 4, -(ONE / 8));
      end
    end

    // R4 exact half: +0.5 rounds up, -0.5 rounds to zero
    doReset("R1 reset mid run");
    setCoef(0, ONE / 2, 0);
    step(1'b1, 1, "R4 positive half sum");
    setCoef(ONE, 0, 0);
    step(1'b1, 0, "R4 state 1 after +half");
    setCoef(0, ONE / 2, 0);
    step(1'b1, -1, "R4 negative half sum");
    setCoef(ONE, 0, 0);
    step(1'b1, 0, "R4 state 0 after -half");
    setCoef(0, ONE / 4, 0);
    step(1'b1, 3, "R4 0.75 sum");
    setCoef(ONE, 0, 0);
    step(1'b1, 0, "R4 state 1 after 0.75");

    // R6 R5 integrator ramp and clamp, both directions
    doReset("R1 reset before integrator");
    setCoef(ONE, ONE, 0);
    for (int i = 0; i < 5; i++) step(1'b1, 12000, "R6 integrator ramp up");
    setCoef(ONE, 0, 0);
    step(1'b1, 0, "R5 clamp at max");
    setCoef(ONE, ONE, 0);
    for (int i = 0; i < 8; i++) step(1'b1, -15000, "R6 integrator ramp down");
    setCoef(ONE, 0, 0);
    step(1'b1, 0, "R5 clamp at min");

    // R7 differentiator
    doReset("R1 reset before differentiator");
    setCoef(0, ONE, ONE);
    for (int i = 0; i < 4; i++) step(1'b1, 1000, "R7 constant input");
    step(1'b1, 3000, "R7 step input");
    step(1'b1, 3000, "R7 settled");
    step(1'b1, -500, "R7 negative step");

    // R8 extreme coefficients and inputs
    setCoef(SMIN, SMAX, SMIN);
    step(1'b1, SMIN, "R8 extreme a");
    step(1'b1, SMIN, "R8 extreme b");
    step(1'b1, SMAX, "R8 extreme c");
    setCoef(SMAX, SMIN, SMAX);
    step(1'b1, SMAX, "R8 extreme d");
    step(1'b1, SMIN, "R8 extreme e");
    step(1'b0, 0, "R3 idle after extreme");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule